// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a stream of compressed code bytes into the serial bit stream that loads a programmable logic device. Bytes arrive on a valid/ready handshake. Bits leave one per clock on a second valid/ready handshake. The block marks the final bit of a stream.

Each stream starts with a fixed 16-bit header. After the header, each code byte expands into a run of identical bits. The run may be closed by one bit of the opposite value, as the code table below defines. The boundary between the codes that give runs of ones and the codes that give runs of zeros is a parameter, `SPLIT`, which defaults to 226. The bit value of every output bit in the requirements below is the value of `outBit` while `outValid` is high.

After the final bit of a stream has been handed over, the block begins the header of the next stream on its own. A source can therefore send streams back to back.

Top module: `rle_cfg_expander`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its header state. In the cycle after reset, `outValid` is 1, `outBit` is 1 and `inReady` is 0.
- R2: The block hands over the 16 header bits before it accepts any code byte. The bits are 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0, which is 0xFF followed by 0x20, most significant bit first.
- R3: A code n in the range 1 to 226 gives n one-bits followed by a single zero-bit.
- R4: Code 227 gives 226 one-bits and no closing bit.
- R5: A code n in the range 228 to 254 gives n-228 zero-bits followed by a single one-bit. Code 228 therefore gives only one 1.
- R6: Code 255 gives a single one-bit.
- R7: Code 0 is accepted through the input handshake and gives no output bits.
- R8: `inReady` is high only when no header or run bit is waiting. `inReady` and `outValid` are never high in the same cycle.
- R9: While `outValid` is high and `outReady` is low, `outValid` stays high and `outBit` holds its value into the next cycle.
- R10: `outLast` is high only with the final bit of the run that comes from a byte carrying `inLast`. When that final byte is code 0, no bit is marked.
- R11: After the final bit of a stream is handed over, or after a final code 0 is accepted, the block returns to the header state and sends the header again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inByte | input | 8 | Code byte |
| inValid | input | 1 | Code byte present |
| inLast | input | 1 | Code byte is the final one of its stream |
| inReady | output | 1 | Block takes a code byte this cycle |
| outBit | output | 1 | Serial configuration bit |
| outValid | output | 1 | `outBit` is valid |
| outLast | output | 1 | `outBit` is the final bit of the stream |
| outReady | input | 1 | Sink takes `outBit` this cycle |

## Verification
Several rules are checked by assertions on every cycle:
- the state right after reset;
- that input and output are never active together;
- that a stalled bit is held steady;
- that a marked final bit is valid and leads back to the header;
- that a run with no closing bit never holds a zero count.

The exact bit sequence of each code class, the header contents and order, and the silent swallowing of code 0 can only be shown by the bench. The bench compares every handed-over bit against an expansion computed independently. It does this under random back-pressure, using directed codes at each class boundary and random streams.

// File: rtl/rlecfg_pkg.sv
package rlecfg_pkg;

  typedef enum logic [1:0] {
    ST_PREFIX,
    ST_IDLE,
    ST_RUN
  } ctlState_t;

  typedef struct packed {
    logic prefixStep;
    logic loadRun;
    logic runStep;
    logic selRun;
  } dpStrobe_t;

endpackage

// File: rtl/rlecfg_datapath.sv
module rlecfg_datapath
  import rlecfg_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SPLIT = 226,
  parameter int PREFIX_LEN = 16,
  parameter logic [PREFIX_LEN-1:0] PREFIX_WORD = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         ctl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              lastIn,
  output logic              codeIsZero,
  output logic              prefixEnd,
  output logic              runFinal,
  output logic              runIsLast,
  output logic              outBit
);

  localparam int IDX_W = $clog2(PREFIX_LEN);
  localparam logic [CODE_W-1:0] MAX_V   = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] SPLIT_V = CODE_W'(SPLIT);
  localparam logic [CODE_W-1:0] UNT_V   = CODE_W'(SPLIT + 1);
  localparam logic [CODE_W-1:0] ZBASE_V = CODE_W'(SPLIT + 2);
  localparam logic [CODE_W-1:0] ONE_V   = CODE_W'(1);
  localparam logic [IDX_W-1:0]  IDX_END = IDX_W'(PREFIX_LEN - 1);

  // Header position counter.
  logic [IDX_W-1:0] prefixIdx;

  // Run state.
  logic [CODE_W-1:0] runCnt;
  logic              bodyBit;
  logic              needTerm;

  // Decoded form of the incoming code.
  logic [CODE_W-1:0] decCnt;
  logic              decBody;
  logic              decTerm;

  logic prefixBit;
  logic runBit;

  // Turn a code into a run description: a length, the value of the body
  // bits, and whether a closing bit of the opposite value follows.
  always_comb begin
    decCnt  = codeIn;
    decBody = 1'b1;
    decTerm = 1'b1;
    if (codeIn == MAX_V) begin
      decCnt  = ONE_V;
      decBody = 1'b1;
      decTerm = 1'b0;
    end else if (codeIn >= ZBASE_V) begin
      decCnt  = codeIn - ZBASE_V;
      decBody = 1'b0;
      decTerm = 1'b1;
    end else if (codeIn == UNT_V) begin
      decCnt  = SPLIT_V;
      decBody = 1'b1;
      decTerm = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prefixIdx <= '0;
    end else if (ctl.prefixStep) begin
      prefixIdx <= prefixEnd ? '0 : prefixIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt    <= '0;
      bodyBit   <= 1'b0;
      needTerm  <= 1'b0;
      runIsLast <= 1'b0;
    end else if (ctl.loadRun) begin
      runCnt    <= decCnt;
      bodyBit   <= decBody;
      needTerm  <= decTerm;
      runIsLast <= lastIn;
    end else if (ctl.runStep) begin
      if (runCnt != '0) begin
        runCnt <= runCnt - 1'b1;
      end else begin
        needTerm <= 1'b0;
      end
    end
  end

  assign codeIsZero = (codeIn == '0);
  assign prefixEnd  = (prefixIdx == IDX_END);
  assign prefixBit  = PREFIX_WORD[IDX_END - prefixIdx];
  assign runBit     = (runCnt != '0) ? bodyBit : ~bodyBit;
  assign runFinal   = needTerm ? (runCnt == '0) : (runCnt == ONE_V);
  assign outBit     = ctl.selRun ? runBit : prefixBit;

  // R4: a run without a closing bit always has body bits left to send.
  p_unterm_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.selRun && !needTerm) |-> (runCnt != '0));

endmodule

// File: rtl/rlecfg_control.sv
module rlecfg_control
  import rlecfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outReady,
  input  logic      codeIsZero,
  input  logic      prefixEnd,
  input  logic      runFinal,
  input  logic      runIsLast,
  output dpStrobe_t ctl,
  output logic      inReady,
  output logic      outValid,
  output logic      outLast
);

  ctlState_t state;
  ctlState_t nextState;

  always_comb begin
    nextState      = state;
    ctl            = '0;
    ctl.selRun     = (state == ST_RUN);
    unique case (state)
      ST_PREFIX: begin
        if (outReady) begin
          ctl.prefixStep = 1'b1;
          if (prefixEnd) nextState = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (inValid) begin
          if (codeIsZero) begin
            if (inLast) nextState = ST_PREFIX;
          end else begin
            ctl.loadRun = 1'b1;
            nextState   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (outReady) begin
          ctl.runStep = 1'b1;
          if (runFinal) nextState = runIsLast ? ST_PREFIX : ST_IDLE;
        end
      end
      default: nextState = ST_PREFIX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PREFIX;
    else     state <= nextState;
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state != ST_IDLE);
  assign outLast  = (state == ST_RUN) && runFinal && runIsLast;

  // R11: a handed-over final bit is followed by the header.
  p_restart_prefix_r11: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> (state == ST_PREFIX));

  // R11: an accepted final zero code also returns to the header.
  p_zero_last_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (inReady && inValid && inLast && codeIsZero) |=> (state == ST_PREFIX));

endmodule

// File: rtl/rle_cfg_expander.sv
module rle_cfg_expander
  import rlecfg_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SPLIT = 226,
  parameter int PREFIX_LEN = 16,
  parameter logic [PREFIX_LEN-1:0] PREFIX_WORD = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              outBit,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady
);

  dpStrobe_t ctl;
  logic codeIsZero;
  logic prefixEnd;
  logic runFinal;
  logic runIsLast;

  rlecfg_control ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inLast     (inLast),
    .outReady   (outReady),
    .codeIsZero (codeIsZero),
    .prefixEnd  (prefixEnd),
    .runFinal   (runFinal),
    .runIsLast  (runIsLast),
    .ctl        (ctl),
    .inReady    (inReady),
    .outValid   (outValid),
    .outLast    (outLast)
  );

  rlecfg_datapath #(
    .CODE_W      (CODE_W),
    .SPLIT       (SPLIT),
    .PREFIX_LEN  (PREFIX_LEN),
    .PREFIX_WORD (PREFIX_WORD)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .codeIn     (inByte),
    .lastIn     (inLast),
    .codeIsZero (codeIsZero),
    .prefixEnd  (prefixEnd),
    .runFinal   (runFinal),
    .runIsLast  (runIsLast),
    .outBit     (outBit)
  );

  // R1: reset leaves the block presenting the first header bit.
  p_reset_prefix_r1: assert property (@(posedge clk)
    rst |=> (outValid && outBit && !inReady));

  // R8: the input side and the output side never act in the same cycle.
  p_one_side_r8: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R9: a stalled bit keeps its value and stays valid.
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outBit)));

  // R10: the final-bit mark only appears on a valid bit.
  p_last_valid_r10: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

endmodule

// File: tb/rle_cfg_expander_tb_top.sv
module rle_cfg_expander_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic       outBit;
  logic       outValid;
  logic       outLast;
  logic       outReady = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  bit sinkOn = 1'b0;

  bit    expBit[$];
  bit    expLast[$];
  string expTag[$];

  always #5 clk = ~clk;

  rle_cfg_expander dut_i (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outBit(outBit), .outValid(outValid), .outLast(outLast),
    .outReady(outReady)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void pushBit(input bit b, input bit l, input string tag);
    expBit.push_back(b);
    expLast.push_back(l);
    expTag.push_back(tag);
  endfunction

  // R2: header 0xFF then 0x20, most significant bit first.
  function automatic void pushPrefix();
    logic [15:0] word = 16'hFF20;
    for (int i = 15; i >= 0; i--) pushBit(word[i], 1'b0, "R2");
  endfunction

  // Expected expansion of one code according to the code table.
  function automatic void pushCode(input int code, input bit last);
    int n;
    if (code >= 1 && code <= 226) begin
      for (int i = 0; i < code; i++) pushBit(1'b1, 1'b0, "R3");
      pushBit(1'b0, last, "R3");
    end else if (code == 227) begin
      for (int i = 0; i < 226; i++) pushBit(1'b1, last && (i == 225), "R4");
    end else if (code >= 228 && code <= 254) begin
      n = code - 228;
      for (int i = 0; i < n; i++) pushBit(1'b0, 1'b0, "R5");
      pushBit(1'b1, last, "R5");
    end else if (code == 255) begin
      pushBit(1'b1, last, "R6");
    end
    // R7: code 0 adds nothing. R11: a final byte is followed by a new header.
    if (last) pushPrefix();
  endfunction

  task automatic sendByte(input int code, input bit last);
    @(negedge clk);
    inByte  = 8'(code);
    inLast  = last;
    inValid = 1'b1;
    pushCode(code, last);
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inLast  = 1'b0;
    if (code == 0) check(1'b1, "R7", "zero code accepted", 1, 1);
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  function automatic int randCode();
    int k = $urandom_range(0, 9);
    case (k)
      0:       return 0;
      1, 2:    return $urandom_range(1, 226);
      3:       return 227;
      4, 5:    return $urandom_range(228, 254);
      6:       return 255;
      default: return $urandom_range(1, 8);
    endcase
  endfunction

  // Output sink: random back-pressure, bit-by-bit comparison.
  initial begin
    bit holdPend = 1'b0;
    bit heldBit = 1'b0;
    bit eb;
    bit el;
    string et;
    wait (sinkOn);
    forever begin
      @(negedge clk);
      outReady = ($urandom_range(0, 3) != 0);
      #1;
      check(!(inReady && outValid), "R8", "inReady with outValid", int'(inReady), 0);
      if (holdPend) begin
        check(outValid && (outBit == heldBit), "R9", "stalled bit held",
              int'(outBit), int'(heldBit));
      end
      holdPend = outValid && !outReady;
      heldBit  = outBit;
      if (!outValid) begin
        check(!outLast, "R10", "last without valid", int'(outLast), 0);
      end
      if (outValid && outReady) begin
        if (expBit.size() == 0) begin
          check(1'b0, "R2", "unexpected output bit", int'(outBit), -1);
        end else begin
          eb = expBit.pop_front();
          el = expLast.pop_front();
          et = expTag.pop_front();
          check(outBit == eb, et, "bit value", int'(outBit), int'(eb));
          check(outLast == el, "R10", "last flag", int'(outLast), int'(el));
        end
      end
    end
  end

  initial begin
    int len;
    void'($urandom(32'd4711));
    pushPrefix();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(outValid && outBit && !inReady, "R1", "state after reset",
          int'({outValid, outBit, inReady}), 6);
    sinkOn = 1'b1;

    // Directed: every class boundary, stream ends on a run.
    sendByte(5, 0);
    sendByte(0, 0);
    sendByte(226, 0);
    sendByte(227, 0);
    sendByte(228, 0);
    sendByte(229, 0);
    sendByte(254, 0);
    sendByte(255, 0);
    sendByte(1, 1);
    // Directed: stream ending on a zero code (no marked bit).
    sendByte(230, 0);
    sendByte(0, 1);
    // Directed: one-byte stream with unterminated run as the final byte.
    sendByte(227, 1);

    // Random streams.
    for (int s = 0; s < 8; s++) begin
      len = $urandom_range(1, 16);
      for (int i = 0; i < len; i++) sendByte(randCode(), i == len - 1);
    end

    while (expBit.size() > 16) @(negedge clk);
    repeat (40) @(negedge clk);
    check(expBit.size() == 0, "R11", "header after final stream drained",
          expBit.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule